// File: doc/BRIEF.md
# Serial Key Debug Unlock Gate

This block guards the debug and boot controls of a device that sits behind a JTAG test access port. When the security strap is high the device comes out of reset locked. In that state debug access is off and external boot sources are refused, so the device can only start from its internal memory. To open it, a 64-bit key is shifted in serially, one bit per shift strobe, least significant bit first. The collected word is compared against a stored secret only when an update strobe arrives.

A matching key opens the gate one clock later, and the gate then stays open until the next reset. A key that does not match leaves every output as it was and gives no indication that an attempt took place. Every update empties the collection register, so each attempt starts from all zeros. The serial return line never shows shifted data. When the security strap is low, the gate is open at all times.

The surrounding logic supplies the shift and update strobes, which are decoded from its own TAP controller, and it supplies the stored secret. The full TAP state machine and the storage of the secret are handled outside this block.

Top module: `key_unlock_gate`

## Requirements
- R1: With `secure_strap_i` high, after reset `unlocked_o`, `debug_en_o` and `ext_boot_ok_o` are all 0.
- R2: With `secure_strap_i` low, `unlocked_o`, `debug_en_o` and `ext_boot_ok_o` are all 1, during reset and after it.
- R3: Bits enter on `tdi_i` while `shift_en_i` is high, least significant bit first. The first bit shifted lands in bit 0 of the 64-bit word once 64 bits are in. If the word equals `secret_key_i` when `update_en_i` is sampled high, all three enables read 1 from the next clock cycle.
- R4: An update with a word that differs from the secret leaves all three enables at 0. This includes a word that holds the key in most-significant-bit-first order.
- R5: Shifting the exact key without an update strobe does not open the gate.
- R6: Each update clears the collected word to zero. A partial shift is compared as-is, and bits from an earlier attempt never combine with bits from a later one.
- R7: Once open, the gate stays open until reset. Later wrong keys and changes on `secret_key_i` do not close it, and a reset closes it again.
- R8: `scan_out_o` is 0 at all times, so shifted data cannot be read back.
- R9: A correct full key succeeds after any number of failed attempts.
- R10: If shift and update are high in the same cycle, the update compares the word as it was before that cycle, and the bit offered in that cycle is discarded.
- R11: `debug_en_o` and `ext_boot_ok_o` always equal `unlocked_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Test clock |
| rst_n_i | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| secure_strap_i | input | 1 | Security enable strap; high selects locked operation |
| secret_key_i | input | 64 | Stored secret key |
| shift_en_i | input | 1 | Shift strobe from the TAP decode |
| update_en_i | input | 1 | Update strobe from the TAP decode |
| tdi_i | input | 1 | Serial key data |
| scan_out_o | output | 1 | Serial return line, held at 0 |
| unlocked_o | output | 1 | Gate open |
| debug_en_o | output | 1 | Emulation and debug access enable |
| ext_boot_ok_o | output | 1 | External boot sources allowed |

## Verification
The checker watches several behaviours on every cycle. It confirms that a locked, secured device never drives either enable. It confirms that the open state only rises in the cycle after an update and never falls outside reset. It also confirms that the strap-low bypass holds, that the return line stays silent, and that the three enables agree. Some properties can only be shown by the bench's scenarios, because they depend on whole serial sequences: the bit order of the key, that a comparison needs the update strobe, that the word is cleared between attempts, and that a shift colliding with an update is discarded.

// File: rtl/key_gate_pkg.sv
package key_gate_pkg;
  typedef enum logic {
    GATE_LOCKED = 1'b0,
    GATE_OPEN   = 1'b1
  } gate_state_e;
endpackage

// File: rtl/kg_rst_sync.sv
// Asynchronous assertion, synchronous release of the active-low reset.
module kg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_n_i,
  output logic rst_n_o
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_n_o = chain_q[STAGES-1];
endmodule

// File: rtl/kg_shift_reg.sv
// Key collection register: LSB-first serial entry, cleared on each compare.
module kg_shift_reg #(
  parameter int KEY_W = 64
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             shift_en_i,
  input  logic             clear_en_i,
  input  logic             bit_i,
  output logic [KEY_W-1:0] word_o
);
  logic [KEY_W-1:0] word_q;
  logic [KEY_W-1:0] word_d;
  logic             word_ce;

  // clear wins over shift: a colliding bit is dropped
  assign word_ce = clear_en_i | shift_en_i;

  always_comb begin
    if (clear_en_i) word_d = '0;
    else            word_d = {bit_i, word_q[KEY_W-1:1]};
  end

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)     word_q <= '0;
    else if (word_ce) word_q <= word_d;
  end

  assign word_o = word_q;
endmodule

// File: rtl/kg_comparator.sv
// Lane-split equality compare of the collected word against the secret.
module kg_comparator #(
  parameter int KEY_W  = 64,
  parameter int LANE_W = 16
) (
  input  logic [KEY_W-1:0] word_i,
  input  logic [KEY_W-1:0] secret_i,
  output logic             match_o
);
  localparam int LANES = KEY_W / LANE_W;

  logic [LANES-1:0] lane_hit;

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    assign lane_hit[g] = (word_i[g*LANE_W +: LANE_W] == secret_i[g*LANE_W +: LANE_W]);
  end

  assign match_o = &lane_hit;
endmodule

// File: rtl/kg_lock_fsm.sv
// Sticky lock state: leaves LOCKED only on an update with a matching word.
module kg_lock_fsm
  import key_gate_pkg::*;
(
  input  logic clk_i,
  input  logic rst_n_i,
  input  logic update_en_i,
  input  logic match_i,
  output logic open_o
);
  gate_state_e state_q;
  gate_state_e state_d;
  logic        state_ce;

  always_comb begin
    state_d = state_q;
    if (state_q == GATE_LOCKED && update_en_i && match_i) state_d = GATE_OPEN;
  end

  assign state_ce = (state_q == GATE_LOCKED) & update_en_i;

  always_ff @(posedge clk_i or negedge rst_n_i) begin
    if (!rst_n_i)      state_q <= GATE_LOCKED;
    else if (state_ce) state_q <= state_d;
  end

  assign open_o = (state_q == GATE_OPEN);
endmodule

// File: rtl/key_unlock_gate.sv
module key_unlock_gate #(
  parameter int KEY_W       = 64,
  parameter int LANE_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_n_i,
  input  logic             secure_strap_i,
  input  logic [KEY_W-1:0] secret_key_i,
  input  logic             shift_en_i,
  input  logic             update_en_i,
  input  logic             tdi_i,
  output logic             scan_out_o,
  output logic             unlocked_o,
  output logic             debug_en_o,
  output logic             ext_boot_ok_o
);
  logic             rst_n_sync;
  logic [KEY_W-1:0] collected;
  logic             key_match;
  logic             gate_open;
  logic             grant;

  kg_rst_sync #(.STAGES(SYNC_STAGES)) u_rst_sync (
    .clk_i   (clk_i),
    .rst_n_i (rst_n_i),
    .rst_n_o (rst_n_sync)
  );

  kg_shift_reg #(.KEY_W(KEY_W)) u_shift (
    .clk_i      (clk_i),
    .rst_n_i    (rst_n_sync),
    .shift_en_i (shift_en_i),
    .clear_en_i (update_en_i),
    .bit_i      (tdi_i),
    .word_o     (collected)
  );

  kg_comparator #(.KEY_W(KEY_W), .LANE_W(LANE_W)) u_cmp (
    .word_i   (collected),
    .secret_i (secret_key_i),
    .match_o  (key_match)
  );

  kg_lock_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_n_i     (rst_n_sync),
    .update_en_i (update_en_i),
    .match_i     (key_match),
    .open_o      (gate_open)
  );

  assign grant         = gate_open | ~secure_strap_i;
  assign unlocked_o    = grant;
  assign debug_en_o    = grant;
  assign ext_boot_ok_o = grant;
  assign scan_out_o    = 1'b0;
endmodule

// File: rtl/key_unlock_gate_chk.sv
module key_unlock_gate_chk (
  input logic clk_i,
  input logic rst_n_i,
  input logic secure_strap_i,
  input logic update_en_i,
  input logic gate_open,
  input logic scan_out_o,
  input logic unlocked_o,
  input logic debug_en_o,
  input logic ext_boot_ok_o
);
  // R1 / R4: a secured, locked device grants nothing
  assert_locked_blocks_R4: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (secure_strap_i && !gate_open) |-> (!debug_en_o && !ext_boot_ok_o));

  // R2: strap low opens everything
  assert_strap_bypass_R2: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    !secure_strap_i |-> (unlocked_o && debug_en_o && ext_boot_ok_o));

  // R3: opening only follows an update strobe
  assert_open_after_update_R3: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    $rose(gate_open) |-> $past(update_en_i));

  // R7: open state is sticky
  assert_open_sticky_R7: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    gate_open |=> gate_open);

  // R8: no readback
  assert_no_readback_R8: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    scan_out_o == 1'b0);

  // R11: enables agree
  assert_enables_agree_R11: assert property (@(posedge clk_i) disable iff (!rst_n_i)
    (debug_en_o == unlocked_o) && (ext_boot_ok_o == unlocked_o));
endmodule

bind key_unlock_gate key_unlock_gate_chk u_chk (
  .clk_i          (clk_i),
  .rst_n_i        (rst_n_i),
  .secure_strap_i (secure_strap_i),
  .update_en_i    (update_en_i),
  .gate_open      (gate_open),
  .scan_out_o     (scan_out_o),
  .unlocked_o     (unlocked_o),
  .debug_en_o     (debug_en_o),
  .ext_boot_ok_o  (ext_boot_ok_o)
);

// File: tb/tb_key_unlock_gate.sv
`timescale 1ns/1ps
module tb_key_unlock_gate;
  localparam logic [63:0] SECRET = 64'hA5C3_19E7_0F2D_B486;

  logic        clk_i = 1'b0;
  logic        rst_n_i;
  logic        secure_strap_i;
  logic [63:0] secret_key_i;
  logic        shift_en_i;
  logic        update_en_i;
  logic        tdi_i;
  logic        scan_out_o;
  logic        unlocked_o;
  logic        debug_en_o;
  logic        ext_boot_ok_o;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;
  bit scan_seen_high = 1'b0;

  always #2 clk_i = ~clk_i;

  key_unlock_gate dut (
    .clk_i(clk_i), .rst_n_i(rst_n_i), .secure_strap_i(secure_strap_i),
    .secret_key_i(secret_key_i), .shift_en_i(shift_en_i), .update_en_i(update_en_i),
    .tdi_i(tdi_i), .scan_out_o(scan_out_o), .unlocked_o(unlocked_o),
    .debug_en_o(debug_en_o), .ext_boot_ok_o(ext_boot_ok_o)
  );

  task automatic check_bit(input string req, input logic act, input logic exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%b expected=%b", req, act, exp);
    end
  endtask

  task automatic check_all(input string req, input logic exp);
    check_bit({req, " unlocked"}, unlocked_o, exp);
    check_bit({req, " debug_en"}, debug_en_o, exp);
    check_bit({req, " ext_boot"}, ext_boot_ok_o, exp);
  endtask

  task automatic apply_reset(input logic strap);
    @(negedge clk_i);
    secure_strap_i = strap; shift_en_i = 0; update_en_i = 0; tdi_i = 0;
    rst_n_i = 0;
    repeat (3) @(negedge clk_i);
    rst_n_i = 1;
    repeat (4) @(negedge clk_i);
  endtask

  // shift n bits of val starting at bit lo, lowest first
  task automatic shift_bits(input logic [63:0] val, input int lo, input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk_i);
      if (scan_out_o !== 1'b0) scan_seen_high = 1'b1;
      shift_en_i = 1; tdi_i = val[lo+i];
    end
    @(negedge clk_i);
    shift_en_i = 0; tdi_i = 0;
  endtask

  task automatic pulse_update();
    @(negedge clk_i);
    update_en_i = 1;
    @(negedge clk_i);
    update_en_i = 0;
  endtask

  task automatic t_reset_state();
    apply_reset(1'b1);
    check_all("R1 reset", 1'b0);
    check_bit("R8 scan idle", scan_out_o, 1'b0);
  endtask

  task automatic t_no_update();
    apply_reset(1'b1);
    shift_bits(SECRET, 0, 64);
    repeat (3) @(negedge clk_i);
    check_all("R5 shift without update", 1'b0);
  endtask

  task automatic t_wrong_keys();
    logic [63:0] rev;
    apply_reset(1'b1);
    shift_bits(SECRET ^ 64'h1, 0, 64);
    pulse_update();
    check_all("R4 one-bit-off key", 1'b0);
    for (int i = 0; i < 64; i++) rev[i] = SECRET[63-i];
    shift_bits(rev, 0, 64);
    pulse_update();
    check_all("R4 msb-first key", 1'b0);
    check_bit("R8 no readback while shifting", scan_seen_high, 1'b0);
  endtask

  task automatic t_partial_and_clear();
    apply_reset(1'b1);
    shift_bits(SECRET, 0, 32);
    pulse_update();
    check_all("R6 partial low half", 1'b0);
    shift_bits(SECRET, 32, 32);
    pulse_update();
    check_all("R6 halves do not combine", 1'b0);
  endtask

  task automatic t_collision();
    apply_reset(1'b1);
    shift_bits(SECRET, 0, 63);
    @(negedge clk_i);
    shift_en_i = 1; tdi_i = SECRET[63]; update_en_i = 1;
    @(negedge clk_i);
    shift_en_i = 0; tdi_i = 0; update_en_i = 0;
    check_all("R10 colliding bit dropped", 1'b0);
  endtask

  task automatic t_unlock_sticky();
    apply_reset(1'b1);
    shift_bits(SECRET ^ 64'hFF00, 0, 64);
    pulse_update();
    check_all("R9 after failure still locked", 1'b0);
    shift_bits(SECRET, 0, 64);
    @(negedge clk_i);
    update_en_i = 1;
    #1;
    check_all("R3 not open before update edge", 1'b0);
    @(negedge clk_i);
    update_en_i = 0;
    check_all("R3 open after correct key", 1'b1);
    check_bit("R11 debug equals unlocked", debug_en_o, unlocked_o);
    shift_bits(64'h0, 0, 64);
    pulse_update();
    check_all("R7 wrong key after open", 1'b1);
    secret_key_i = ~SECRET;
    repeat (2) @(negedge clk_i);
    check_all("R7 secret change after open", 1'b1);
    secret_key_i = SECRET;
    apply_reset(1'b1);
    check_all("R7 reset relocks", 1'b0);
  endtask

  task automatic t_strap_low();
    @(negedge clk_i);
    secure_strap_i = 0; rst_n_i = 0;
    @(negedge clk_i);
    check_all("R2 strap low in reset", 1'b1);
    rst_n_i = 1;
    @(negedge clk_i);
    check_all("R2 strap low after reset", 1'b1);
    shift_bits(64'h0, 0, 64);
    pulse_update();
    check_all("R2 strap low wrong key", 1'b1);
  endtask

  initial begin
    rst_n_i = 0; secure_strap_i = 1; secret_key_i = SECRET;
    shift_en_i = 0; update_en_i = 0; tdi_i = 0;
    t_reset_state();
    t_no_update();
    t_wrong_keys();
    t_partial_and_clear();
    t_collision();
    t_unlock_sticky();
    t_strap_low();
    if (!done) begin
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    #200000;
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
    end
  end
endmodule